// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block holds bytes delivered by a serial deserializer until the processor reads them. Bytes sit in a circular store that is tracked by a write pointer and an occupancy count, and the read slot is computed from those two values. A byte that arrives while the store is full is discarded, and a one-cycle overflow pulse is raised. A line break is stored as one zero byte. When receive is disabled, the buffer takes no writes and gives up no data.

Each accepted byte restarts a timeout counter that runs in input clock ticks. The counter expires after four character times and then raises a one-cycle timeout pulse. The character time follows from the frame format in the mode input: a start bit, the data bits, an optional parity bit and the stop bits. Each bit lasts the input clock period, times eight when the prescale bit is set, times the clock divisor, times one more than the baud divider.

Top module: `rxb_top`

## Requirements
- R1: Bytes are read back in arrival order, including across the wrap of the circular store. `rd_data` shows the read result in the cycle after the `rd_strobe` edge.
- R2: `level` equals the number of stored bytes. `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` equals DEPTH (default 64).
- R3: A byte or break that arrives while the buffer is full is dropped. `ovf_pulse` is high for the one cycle that follows the arrival edge, and `level` is unchanged.
- R4: A read while the buffer is enabled and empty returns 0x00 and leaves `level` unchanged.
- R5: While `rx_en` is 0, arriving bytes and breaks are ignored. A read returns 0x00 and consumes nothing.
- R6: A `rx_break` strobe stores a single 0x00 byte. If `rx_valid` is high in the same cycle, only the zero byte is stored.
- R7: Suppose an accepted write happens at clock edge e, and no further write is accepted. Then `tmo_pulse` is high only in the cycle after edge e+T, where T = 4 × character bits × bit clocks. Each accepted write reloads the counter.
- R8: Character bits = 1 + data + parity + stop. Data comes from `frame_mode[2:1]`: 3 → 6 bits, 2 → 7 bits, otherwise 8. Parity comes from `frame_mode[5:3]`: 0 (even) or 1 (odd) adds one bit, and any other code adds none. Stop comes from `frame_mode[7:6]`: 3 → 1 bit, otherwise 2.
- R9: Bit clocks = (8 if `frame_mode[0]` is 1, else 1) × max(`clk_div`, 1) × (`baud_div` + 1).
- R10: After reset, `level` is 0, `empty` is 1, `full` is 0, and `rd_data`, `ovf_pulse` and `tmo_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive path enable |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break condition strobe |
| frame_mode | input | 8 | Prescale, data length, parity and stop fields |
| clk_div | input | DIV_W | Clock divisor (0 treated as 1) |
| baud_div | input | BDIV_W | Baud divider (bit clocks scale by value + 1) |
| rd_strobe | input | 1 | Processor read of the data register |
| rd_data | output | 8 | Result of the last read |
| level | output | $clog2(DEPTH)+1 | Stored byte count |
| full | output | 1 | Buffer holds DEPTH bytes |
| empty | output | 1 | Buffer holds no bytes |
| ovf_pulse | output | 1 | One-cycle overflow event |
| tmo_pulse | output | 1 | One-cycle receive timeout event |

## Verification
The store is exercised with a short burst that is read back, then a fill to capacity that wraps the pointer, then a drain. These patterns separate ordering faults from faults in the pointer arithmetic. Arrivals into a full buffer, reads of an empty buffer, and traffic while disabled each check that the state is left alone. A break that coincides with a byte shows which of the two wins. The timeout is measured clock by clock for several frame formats, prescale settings and divider values, including a zero divisor. A restart case shows that the count reloads and does not merely begin on the first byte.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       parity_on;
        logic [1:0] stop_bits;
        logic       prescale8;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_mode(input logic [7:0] mode);
        frame_cfg_t c;
        case (mode[2:1])
            2'd3:    c.data_bits = 4'd6;
            2'd2:    c.data_bits = 4'd7;
            default: c.data_bits = 4'd8;
        endcase
        c.parity_on = (mode[5:3] == 3'd0) || (mode[5:3] == 3'd1);
        c.stop_bits = (mode[7:6] == 2'd3) ? 2'd1 : 2'd2;
        c.prescale8 = mode[0];
        return c;
    endfunction

    function automatic logic [3:0] char_bits(input frame_cfg_t c);
        return 4'd1 + c.data_bits + {3'd0, c.parity_on} + {2'd0, c.stop_bits};
    endfunction

endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
    parameter int DEPTH = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_en,
    output logic [7:0]       rd_word,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [7:0]        mem [DEPTH];
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rpos;

    // read slot trails the write pointer by the occupancy, modulo depth
    assign rpos    = wptr - count[ADDR_W-1:0];
    assign rd_word = mem[rpos];
    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= wptr + ADDR_W'(1);
            case ({wr_en, rd_en})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxb_timer.sv
module rxb_timer
    import rxb_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int BDIV_W = 8,
    localparam int TMR_W = DIV_W + BDIV_W + 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        frame_mode,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [BDIV_W-1:0] baud_div,
    input  logic              restart,
    output logic              tmo_pulse
);
    frame_cfg_t       cfg;
    logic [DIV_W-1:0] div_eff;
    logic [TMR_W-1:0] bit_clks;
    logic [TMR_W-1:0] span;
    logic [TMR_W-1:0] remain;

    assign cfg     = decode_mode(frame_mode);
    assign div_eff = (clk_div == '0) ? DIV_W'(1) : clk_div;

    always_comb begin
        bit_clks = TMR_W'(div_eff) * (TMR_W'(baud_div) + TMR_W'(1));
        if (cfg.prescale8) bit_clks = bit_clks << 3;
        span = (bit_clks * TMR_W'(char_bits(cfg))) << 2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remain    <= '0;
            tmo_pulse <= 1'b0;
        end else begin
            tmo_pulse <= 1'b0;
            if (restart) begin
                remain <= span;
            end else if (remain != '0) begin
                remain <= remain - TMR_W'(1);
                if (remain == TMR_W'(1)) tmo_pulse <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxb_top.sv
module rxb_top #(
    parameter int DEPTH = 64,
    parameter int DIV_W = 16,
    parameter int BDIV_W = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_break,
    input  logic [7:0]        frame_mode,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [BDIV_W-1:0] baud_div,
    input  logic              rd_strobe,
    output logic [7:0]        rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              ovf_pulse,
    output logic              tmo_pulse
);
    logic       arrive;
    logic       accept;
    logic       take;
    logic [7:0] wr_byte;
    logic [7:0] head;

    assign arrive  = rx_en && (rx_valid || rx_break);
    assign accept  = arrive && !full;
    assign take    = rx_en && rd_strobe && !empty;
    assign wr_byte = rx_break ? 8'h00 : rx_byte;

    rxb_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_data (wr_byte),
        .rd_en   (take),
        .rd_word (head),
        .count   (level),
        .full    (full),
        .empty   (empty)
    );

    rxb_timer #(.DIV_W(DIV_W), .BDIV_W(BDIV_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_mode (frame_mode),
        .clk_div    (clk_div),
        .baud_div   (baud_div),
        .restart    (accept),
        .tmo_pulse  (tmo_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= 8'h00;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= arrive && full;
            if (rd_strobe) rd_data <= take ? head : 8'h00;
        end
    end
endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic             rx_valid,
    input logic             rx_break,
    input logic             rd_strobe,
    input logic [7:0]       rd_data,
    input logic [CNT_W-1:0] level,
    input logic             full,
    input logic             empty,
    input logic             ovf_pulse,
    input logic             tmo_pulse
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && (rx_valid || rx_break) && full) |=> (ovf_pulse && $stable(level)));

    // R2
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        ##1 (level == $past(level) || level == $past(level) + CNT_W'(1)
             || level + CNT_W'(1) == $past(level)));

    // R2
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R4
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && empty) |=> (rd_data == 8'h00 && $stable(level)));

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> $stable(level));

    // R7
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_en && (rx_valid || rx_break) && !full) |=> !tmo_pulse);
endmodule

bind rxb_top rxb_chk #(.CNT_W(CNT_W)) u_rxb_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .rx_valid  (rx_valid),
    .rx_break  (rx_break),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .level     (level),
    .full      (full),
    .empty     (empty),
    .ovf_pulse (ovf_pulse),
    .tmo_pulse (tmo_pulse)
);

// File: tb/test_rxb_top.sv
module test_rxb_top;
    localparam int DEPTH = 64;
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic rx_break = 1'b0;
    logic [7:0] frame_mode = 8'h00;
    logic [15:0] clk_div = 16'd1;
    logic [7:0] baud_div = 8'd0;
    logic rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic [CNT_W-1:0] level;
    logic full, empty, ovf_pulse, tmo_pulse;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    rxb_top i_rxb_top (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_break(rx_break), .frame_mode(frame_mode),
        .clk_div(clk_div), .baud_div(baud_div), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .level(level), .full(full), .empty(empty),
        .ovf_pulse(ovf_pulse), .tmo_pulse(tmo_pulse)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: presents one arrival, predicts acceptance, queues the expected byte
    task automatic push(input logic [7:0] b, input bit brk, input bit also_byte, output bit dropped);
        bit acc;
        acc = rx_en && (exp_q.size() < DEPTH);
        dropped = rx_en && !acc;
        @(negedge clk);
        rx_valid = !brk || also_byte;
        rx_byte = b;
        rx_break = brk;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        rx_break = 1'b0;
        if (acc) exp_q.push_back(brk ? 8'h00 : b);
    endtask

    // monitor: issues a read and compares against the scoreboard
    task automatic pull(input string req);
        logic [7:0] e;
        e = (rx_en && exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        @(negedge clk);
        rd_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_strobe = 1'b0;
        check(rd_data === e, req, rd_data, e);
        check(level === CNT_W'(exp_q.size()), req, level, exp_q.size());
    endtask

    // timeout measurement: clocks from accepting edge to the pulse
    task automatic measure(input longint t_exp, input string req);
        bit dummy;
        longint k;
        bit early;
        push(8'hA5, 1'b0, 1'b0, dummy);
        k = 0;
        early = 1'b0;
        while (!tmo_pulse && k < 3000) begin
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        check(k == t_exp, req, k, t_exp);
        @(posedge clk);
        @(negedge clk);
        check(tmo_pulse === 1'b0, {req, " pulse width"}, tmo_pulse, 0);
        void'(exp_q.pop_front());
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit dr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(level === '0 && empty === 1'b1 && full === 1'b0, "R10", level, 0);
        check(rd_data === 8'h00 && ovf_pulse === 1'b0 && tmo_pulse === 1'b0, "R10", rd_data, 0);

        rx_en = 1'b1;
        // R1 short burst, ordered read-back
        push(8'h11, 0, 0, dr);
        push(8'h22, 0, 0, dr);
        push(8'h33, 0, 0, dr);
        check(level === CNT_W'(3), "R2", level, 3);
        pull("R1");
        pull("R1");
        pull("R1");
        check(empty === 1'b1, "R2 empty", empty, 1);

        // R2/R3 fill to capacity (pointer wraps since it starts at 3)
        for (int i = 0; i < DEPTH; i++) push(8'(i * 7 + 1), 0, 0, dr);
        check(full === 1'b1 && level === CNT_W'(DEPTH), "R2 full", level, DEPTH);
        push(8'hEE, 0, 0, dr);
        check(dr && ovf_pulse === 1'b1, "R3 ovf pulse", ovf_pulse, 1);
        check(level === CNT_W'(DEPTH), "R3 level held", level, DEPTH);
        @(negedge clk);
        check(ovf_pulse === 1'b0, "R3 pulse width", ovf_pulse, 0);
        for (int i = 0; i < DEPTH; i++) pull("R1 wrap");

        // R4 read from empty
        pull("R4");
        check(empty === 1'b1 && level === '0, "R4", level, 0);

        // R5 disabled path
        push(8'h5A, 0, 0, dr);
        rx_en = 1'b0;
        push(8'h66, 0, 0, dr);
        push(8'h00, 1, 0, dr);
        check(level === CNT_W'(1), "R5 write ignored", level, 1);
        pull("R5 read gives zero");
        check(level === CNT_W'(1), "R5 nothing consumed", level, 1);
        rx_en = 1'b1;
        pull("R5 byte kept");

        // R6 break stores zero, wins over a coincident byte
        push(8'h00, 1, 0, dr);
        push(8'h77, 1, 1, dr);
        check(level === CNT_W'(2), "R6 one byte per break", level, 2);
        pull("R6");
        pull("R6");

        repeat (100) @(negedge clk);
        // R7/R8 8 data, even parity, 2 stop: 12 bits x 1 clock x 4 = 48
        measure(48, "R7 R8 12-bit frame");
        // R7 restart: second byte 20 clocks later reloads the count
        push(8'h01, 0, 0, dr);
        repeat (20) @(negedge clk);
        check(tmo_pulse === 1'b0, "R7 no early pulse", tmo_pulse, 0);
        measure(48, "R7 restart");
        void'(exp_q.pop_front());
        @(negedge clk); rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        // R8 7 data, even parity, 1 stop: 10 bits -> 40
        frame_mode = 8'hC4;
        measure(40, "R8 10-bit frame");
        // R9 zero divisor treated as one: 6 data, no parity, 1 stop -> 32
        frame_mode = 8'hE6;
        clk_div = 16'd0;
        measure(32, "R9 zero divisor");
        // R9 prescale 8, divisor 2, baud 1: 8 bits x 32 clocks x 4 = 1024
        frame_mode = 8'hE7;
        clk_div = 16'd2;
        baud_div = 8'd1;
        measure(1024, "R9 prescale");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule